// File: doc/BRIEF.md
# Directory Home-Node Coherence Controller

This block sits at the home node of a distributed-memory multiprocessor. It keeps a directory entry for each memory block it owns. The entry holds a coherence state (Uncached, Shared or Exclusive) and a sharer vector with one bit per processor. It also holds the backing memory word for that block.

Cache controllers send it read misses, write misses and write-backs. The controller answers with point-to-point messages: a data reply, an invalidate, a fetch, or a fetch-with-invalidate. It never broadcasts. Each message goes to one processor named in the sharer vector.

When the current value is held in an owner's cache, the controller asks the owner for the data. It then waits on a separate owner-data port. When the data arrives, it is written to memory and forwarded to the requester. The controller handles one transaction at a time. While any transaction is open, including the wait for owner data, new requests are held off.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset, every block is Uncached with an empty sharer vector, and the memory word of block b holds the value b. Also after reset, `req_ready` is high, and `out_valid` and `fd_ready` are low.
- R2: A read miss (request kind 0) to an Uncached or Shared block produces one data reply (message kind 0) to the requester, carrying the block's memory word. The requester is added to the sharer vector and the block becomes Shared.
- R3: A write miss (request kind 1) to an Uncached block produces one data reply to the requester. The requester becomes the sole owner and the block becomes Exclusive.
- R4: A write miss to a Shared block first sends one invalidate (message kind 1) to each sharer other than the requester, in ascending processor number, one per output handshake. It then sends the data reply, and the requester becomes the sole owner in Exclusive. If the requester is the only sharer, no invalidate is sent.
- R5: A read miss to an Exclusive block sends a fetch (message kind 2) to the owner and waits for data on the owner-data port. That data is written to memory and replied to the requester. The old owner stays in the sharer vector, the requester is added, and the block becomes Shared.
- R6: A write miss to an Exclusive block sends a fetch/invalidate (message kind 3) to the owner. The returned data is written to memory and replied to the requester, who becomes the sole owner in Exclusive.
- R7: A write-back (request kind 2) from the owner of an Exclusive block writes its data to memory and makes the block Uncached with an empty sharer vector. No message is sent.
- R8: A write-back from a processor that is not the owner, a write-back to a block that is not Exclusive, and request kind 3 are all accepted and have no effect. No message is sent, and memory and directory state are unchanged.
- R9: `req_ready` is low from the acceptance of a request until the last message of that transaction is taken, including the whole wait for owner data. `fd_ready` is high only while owner data is awaited.
- R10: While `out_valid` is high and `out_ready` is low, all output message fields hold. `out_addr` carries the block index. `out_data` is zero on every message except a data reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request message present |
| req_ready | output | 1 | Controller can accept a request |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 write-back, 3 no-op |
| req_src | input | clog2(NPROC) | Requesting processor number |
| req_addr | input | clog2(NBLK) | Block index |
| req_data | input | DW | Write-back data |
| fd_valid | input | 1 | Owner data present |
| fd_ready | output | 1 | Controller is waiting for owner data |
| fd_data | input | DW | Data returned by the owner |
| out_valid | output | 1 | Outgoing message present |
| out_ready | input | 1 | Interconnect takes the message |
| out_kind | output | 2 | 0 data reply, 1 invalidate, 2 fetch, 3 fetch/invalidate |
| out_dest | output | clog2(NPROC) | Destination processor |
| out_addr | output | clog2(NBLK) | Block index |
| out_data | output | DW | Reply data, zero otherwise |

## Verification
The embedded properties check, on every cycle, the invariants on the directory entries:
- an Exclusive entry names exactly one owner;
- an Uncached entry has no sharers;
- a Shared entry has at least one sharer.

Other properties also hold on every cycle:
- invalidates skip the requester and rise in processor number;
- owner data is waited on only after a fetch has been taken;
- returned data is forwarded at once;
- write-backs stay silent;
- a stalled message holds its fields.

Some behaviour can only be shown by the bench's scenarios, which compare message streams against a reference directory model. One example is whether a sharer vector holds exactly the right processors. This is seen only when a later write miss produces its invalidates. Another is whether a dropped write-back left memory untouched, which is seen only when a later read returns the old word.

// File: rtl/dir_pkg.sv
package dir_pkg;

    // Directory entry coherence state
    typedef enum logic [1:0] {
        D_UNC = 2'd0,
        D_SHR = 2'd1,
        D_EXC = 2'd2
    } dstate_e;

    // Incoming request kinds (port encoding)
    typedef enum logic [1:0] {
        RQ_RD  = 2'd0,
        RQ_WR  = 2'd1,
        RQ_WB  = 2'd2,
        RQ_NOP = 2'd3
    } rqkind_e;

    // Outgoing message kinds (port encoding)
    typedef enum logic [1:0] {
        MS_DATA  = 2'd0,
        MS_INV   = 2'd1,
        MS_FETCH = 2'd2,
        MS_FINV  = 2'd3
    } mskind_e;

    // Transaction sequencer
    typedef enum logic [2:0] {
        SQ_IDLE = 3'd0,
        SQ_INV  = 3'd1,
        SQ_FET  = 3'd2,
        SQ_WAIT = 3'd3,
        SQ_RPL  = 3'd4
    } seq_e;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/dir_pick.sv
module dir_pick #(
    parameter int N = 4,
    localparam int IW = dir_pkg::idx_width(N)
) (
    input  logic [N-1:0]  vec,
    output logic [N-1:0]  hot,
    output logic [IW-1:0] idx
);
    // seen[g] is set when any bit below g is set
    logic [N-1:0] seen;
    assign seen[0] = 1'b0;

    for (genvar g = 0; g < N; g++) begin : g_chain
        assign hot[g] = vec[g] & ~seen[g];
        if (g < N - 1) begin : g_nx
            assign seen[g+1] = seen[g] | vec[g];
        end
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (hot[i]) idx = idx | IW'(i);
        end
    end
endmodule

// File: rtl/dir_store.sv
module dir_store
    import dir_pkg::*;
#(
    parameter int NPROC = 4,
    parameter int NBLK  = 8,
    parameter int DW    = 16,
    localparam int AW = idx_width(NBLK)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    addr,
    output dstate_e          rd_state,
    output logic [NPROC-1:0] rd_shr,
    output logic [DW-1:0]    rd_data,
    input  logic             we,
    input  dstate_e          wstate,
    input  logic [NPROC-1:0] wshr,
    input  logic             mwe,
    input  logic [DW-1:0]    mdata
);
    dstate_e          st  [NBLK];
    logic [NPROC-1:0] shr [NBLK];
    logic [DW-1:0]    mem [NBLK];

    assign rd_state = st[addr];
    assign rd_shr   = shr[addr];
    assign rd_data  = mem[addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NBLK; i++) begin
                st[i]  <= D_UNC;
                shr[i] <= '0;
                mem[i] <= DW'(i);
            end
        end else begin
            if (we) begin
                st[addr]  <= wstate;
                shr[addr] <= wshr;
            end
            if (mwe) mem[addr] <= mdata;
        end
    end

    // Entry invariants on the looked-up block
    assert_excl_single_R6: assert property (@(posedge clk) disable iff (rst)
        rd_state == D_EXC |-> $countones(rd_shr) == 1);
    assert_unc_empty_R7: assert property (@(posedge clk) disable iff (rst)
        rd_state == D_UNC |-> rd_shr == '0);
    assert_shr_nonempty_R2: assert property (@(posedge clk) disable iff (rst)
        rd_state == D_SHR |-> rd_shr != '0);
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
    import dir_pkg::*;
#(
    parameter int NPROC = 4,
    parameter int NBLK  = 8,
    parameter int DW    = 16,
    localparam int PW = idx_width(NPROC),
    localparam int AW = idx_width(NBLK)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_kind,
    input  logic [PW-1:0] req_src,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    input  logic          fd_valid,
    output logic          fd_ready,
    input  logic [DW-1:0] fd_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [1:0]    out_kind,
    output logic [PW-1:0] out_dest,
    output logic [AW-1:0] out_addr,
    output logic [DW-1:0] out_data
);
    seq_e             seq;
    rqkind_e          cur_kind;
    logic [PW-1:0]    cur_src;
    logic [AW-1:0]    cur_addr;
    logic [PW-1:0]    owner;
    logic [NPROC-1:0] pend;
    logic [DW-1:0]    rdata;

    // directory lookup / update
    logic [AW-1:0]    s_addr;
    dstate_e          rd_state;
    logic [NPROC-1:0] rd_shr;
    logic [DW-1:0]    rd_data;
    logic             t_we, m_we;
    dstate_e          t_state;
    logic [NPROC-1:0] t_shr;
    logic [DW-1:0]    m_wdata;

    // lowest-sharer picker
    logic [NPROC-1:0] p_in, p_hot;
    logic [PW-1:0]    p_idx;

    logic             accept, fd_take;
    logic [NPROC-1:0] src_bit, cur_bit, others;

    assign req_ready = (seq == SQ_IDLE);
    assign fd_ready  = (seq == SQ_WAIT);
    assign accept    = req_valid & req_ready;
    assign fd_take   = fd_valid & fd_ready;
    assign src_bit   = NPROC'(1) << req_src;
    assign cur_bit   = NPROC'(1) << cur_src;
    assign others    = rd_shr & ~src_bit;
    assign s_addr    = (seq == SQ_IDLE) ? req_addr : cur_addr;
    assign p_in      = (seq == SQ_INV) ? pend : rd_shr;

    dir_store #(.NPROC(NPROC), .NBLK(NBLK), .DW(DW)) u_store (
        .clk      (clk),
        .rst      (rst),
        .addr     (s_addr),
        .rd_state (rd_state),
        .rd_shr   (rd_shr),
        .rd_data  (rd_data),
        .we       (t_we),
        .wstate   (t_state),
        .wshr     (t_shr),
        .mwe      (m_we),
        .mdata    (m_wdata)
    );

    dir_pick #(.N(NPROC)) u_pick (
        .vec (p_in),
        .hot (p_hot),
        .idx (p_idx)
    );

    // Directory and memory update decisions
    always_comb begin
        t_we    = 1'b0;
        t_state = rd_state;
        t_shr   = rd_shr;
        m_we    = 1'b0;
        m_wdata = fd_data;
        if (accept) begin
            unique case (rqkind_e'(req_kind))
                RQ_RD: if (rd_state != D_EXC) begin
                    t_we    = 1'b1;
                    t_state = D_SHR;
                    t_shr   = rd_shr | src_bit;
                end
                RQ_WR: if (rd_state != D_EXC) begin
                    t_we    = 1'b1;
                    t_state = D_EXC;
                    t_shr   = src_bit;
                end
                RQ_WB: if (rd_state == D_EXC && rd_shr == src_bit) begin
                    t_we    = 1'b1;
                    t_state = D_UNC;
                    t_shr   = '0;
                    m_we    = 1'b1;
                    m_wdata = req_data;
                end
                default: ;
            endcase
        end else if (fd_take) begin
            t_we = 1'b1;
            m_we = 1'b1;
            if (cur_kind == RQ_WR) begin
                t_state = D_EXC;
                t_shr   = cur_bit;
            end else begin
                t_state = D_SHR;
                t_shr   = rd_shr | cur_bit;
            end
        end
    end

    // Transaction sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            seq      <= SQ_IDLE;
            cur_kind <= RQ_NOP;
            cur_src  <= '0;
            cur_addr <= '0;
            owner    <= '0;
            pend     <= '0;
            rdata    <= '0;
        end else begin
            unique case (seq)
                SQ_IDLE: if (accept) begin
                    cur_kind <= rqkind_e'(req_kind);
                    cur_src  <= req_src;
                    cur_addr <= req_addr;
                    rdata    <= rd_data;
                    owner    <= p_idx;
                    if (req_kind == RQ_RD || req_kind == RQ_WR) begin
                        if (rd_state == D_EXC)
                            seq <= SQ_FET;
                        else if (req_kind == RQ_WR && rd_state == D_SHR && others != '0) begin
                            pend <= others;
                            seq  <= SQ_INV;
                        end else
                            seq <= SQ_RPL;
                    end
                end
                SQ_INV: if (out_ready) begin
                    pend <= pend & ~p_hot;
                    if ((pend & ~p_hot) == '0) seq <= SQ_RPL;
                end
                SQ_FET:  if (out_ready) seq <= SQ_WAIT;
                SQ_WAIT: if (fd_valid) begin
                    rdata <= fd_data;
                    seq   <= SQ_RPL;
                end
                SQ_RPL:  if (out_ready) seq <= SQ_IDLE;
                default: seq <= SQ_IDLE;
            endcase
        end
    end

    // Outgoing message
    always_comb begin
        out_valid = 1'b0;
        out_kind  = MS_DATA;
        out_dest  = cur_src;
        out_addr  = cur_addr;
        out_data  = '0;
        unique case (seq)
            SQ_INV: begin
                out_valid = 1'b1;
                out_kind  = MS_INV;
                out_dest  = p_idx;
            end
            SQ_FET: begin
                out_valid = 1'b1;
                out_kind  = (cur_kind == RQ_WR) ? MS_FINV : MS_FETCH;
                out_dest  = owner;
            end
            SQ_RPL: begin
                out_valid = 1'b1;
                out_data  = rdata;
            end
            default: ;
        endcase
    end

    assert_msg_hold_R10: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid &&
            $stable({out_kind, out_dest, out_addr, out_data}));
    assert_inv_ascend_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && out_kind == MS_INV |=>
            !(out_valid && out_kind == MS_INV) || out_dest > $past(out_dest));
    assert_inv_skip_req_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_kind == MS_INV |-> out_dest != cur_src);
    assert_fetch_first_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(fd_ready) |-> $past(out_valid && out_ready && out_kind[1]));
    assert_fwd_data_R5: assert property (@(posedge clk) disable iff (rst)
        fd_valid && fd_ready |=> out_valid && out_kind == MS_DATA &&
            out_data == $past(fd_data));
    assert_wb_silent_R7: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && req_kind == RQ_WB |=> req_ready && !out_valid);
endmodule

// File: tb/dir_home_ctrl_test.sv
module dir_home_ctrl_test;
    typedef struct packed {
        logic [1:0]  k;
        logic [1:0]  d;
        logic [2:0]  a;
        logic [15:0] v;
    } msg_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = '0;
    logic [1:0]  req_src = '0;
    logic [2:0]  req_addr = '0;
    logic [15:0] req_data = '0;
    logic        fd_valid = 1'b0;
    logic        fd_ready;
    logic [15:0] fd_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [1:0]  out_kind;
    logic [1:0]  out_dest;
    logic [2:0]  out_addr;
    logic [15:0] out_data;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;

    msg_t  q_msg[$];
    string q_tag[$];

    // reference directory model
    int          m_st [8];   // 0 uncached, 1 shared, 2 exclusive
    logic [3:0]  m_shr[8];
    logic [15:0] m_mem[8];

    always #5 clk = ~clk;

    dir_home_ctrl uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_src(req_src), .req_addr(req_addr), .req_data(req_data),
        .fd_valid(fd_valid), .fd_ready(fd_ready), .fd_data(fd_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
        .out_dest(out_dest), .out_addr(out_addr), .out_data(out_data)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s got=%h expected=%h", tag, what, got, exp);
        end
    endtask

    // monitor: set backpressure, then score the message taken at the next edge
    always @(negedge clk) begin
        cyc++;
        out_ready = (cyc % 3) != 1;
        if (!rst && out_valid && out_ready) begin
            if (q_msg.size() == 0) begin
                check(0, "R8", "unexpected message", {out_kind, out_dest, out_addr, out_data}, 0);
            end else begin
                msg_t  e;
                string t;
                e = q_msg.pop_front();
                t = q_tag.pop_front();
                check({out_kind, out_dest, out_addr, out_data} == e, t, "message",
                      {9'd0, out_kind, out_dest, out_addr, out_data}, {9'd0, e});
            end
        end
    end

    function automatic msg_t mk(input int k, input int d, input int a, input logic [15:0] v);
        msg_t m;
        m.k = 2'(k); m.d = 2'(d); m.a = 3'(a); m.v = v;
        return m;
    endfunction

    task automatic expect_msg(input msg_t m, input string tag);
        q_msg.push_back(m);
        q_tag.push_back(tag);
    endtask

    task automatic do_req(input int kind, input int src, input int a,
                          input logic [15:0] data, input logic [15:0] fdat, input string tag);
        logic [3:0] sb;
        int own;
        bit fet;
        sb  = 4'(1 << src);
        own = 0;
        fet = 0;
        for (int p = 0; p < 4; p++) if (m_shr[a][p]) own = p;
        case (kind)
            0: begin
                if (m_st[a] == 2) begin
                    expect_msg(mk(2, own, a, 16'h0), tag);         // R5 fetch
                    expect_msg(mk(0, src, a, fdat), tag);
                    m_mem[a] = fdat;
                    fet = 1;
                end else begin
                    expect_msg(mk(0, src, a, m_mem[a]), tag);     // R2 reply
                end
                m_shr[a] = m_shr[a] | sb;
                m_st[a]  = 1;
            end
            1: begin
                if (m_st[a] == 2) begin
                    expect_msg(mk(3, own, a, 16'h0), tag);         // R6 fetch/inv
                    expect_msg(mk(0, src, a, fdat), tag);
                    m_mem[a] = fdat;
                    fet = 1;
                end else begin
                    if (m_st[a] == 1)
                        for (int p = 0; p < 4; p++)
                            if (m_shr[a][p] && p != src) expect_msg(mk(1, p, a, 16'h0), tag); // R4
                    expect_msg(mk(0, src, a, m_mem[a]), tag);
                end
                m_shr[a] = sb;
                m_st[a]  = 2;
            end
            2: begin
                if (m_st[a] == 2 && m_shr[a] == sb) begin         // R7
                    m_mem[a] = data;
                    m_st[a]  = 0;
                    m_shr[a] = 4'h0;
                end
            end
            default: ;
        endcase

        @(negedge clk);
        req_valid = 1'b1;
        req_kind  = 2'(kind);
        req_src   = 2'(src);
        req_addr  = 3'(a);
        req_data  = data;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;

        if (fet) begin
            while (!fd_ready) @(negedge clk);
            for (int i = 0; i < 2; i++) begin
                check(!req_ready && !out_valid, "R9", "stall during fetch wait",
                      {req_ready, out_valid}, 0);
                @(negedge clk);
            end
            fd_valid = 1'b1;
            fd_data  = fdat;
            @(negedge clk);
            fd_valid = 1'b0;
        end

        if (kind >= 2) begin
            for (int i = 0; i < 3; i++) begin
                check(!out_valid && req_ready, tag, "silent request",
                      {out_valid, req_ready}, 1);
                @(negedge clk);
            end
        end
        while (q_msg.size() != 0 || !req_ready) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired got=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            m_st[i] = 0; m_shr[i] = 4'h0; m_mem[i] = 16'(i);
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state at the ports
        check(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
        check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        check(fd_ready == 1'b0, "R1", "fd_ready after reset", fd_ready, 0);

        do_req(0, 1, 2, 0, 0, "R2");           // uncached read, R1 memory init
        do_req(0, 3, 2, 0, 0, "R2");           // shared read
        do_req(0, 0, 2, 0, 0, "R2");
        do_req(1, 1, 2, 0, 0, "R4");           // inv p0, p3, skip requester
        do_req(0, 2, 2, 0, 16'hBEEF, "R5");    // fetch from owner p1
        do_req(1, 0, 2, 0, 0, "R4");           // inv p1 (old owner kept), p2
        do_req(1, 3, 2, 0, 16'h1234, "R6");    // fetch/inv to p0
        do_req(2, 1, 2, 16'h7777, 0, "R8");    // write-back from non-owner
        do_req(0, 2, 5, 0, 0, "R2");
        do_req(2, 3, 2, 16'hCAFE, 0, "R7");    // owner write-back
        do_req(0, 0, 2, 0, 0, "R7");           // reads back CAFE, block uncached
        do_req(1, 2, 7, 0, 0, "R3");           // uncached write miss
        do_req(2, 2, 5, 16'h9999, 0, "R8");    // write-back to shared block
        do_req(3, 1, 7, 16'h4444, 0, "R8");    // kind 3 no-op
        do_req(0, 1, 7, 0, 16'h55AA, "R5");
        do_req(0, 1, 4, 0, 0, "R2");
        do_req(1, 1, 4, 0, 0, "R4");           // sole sharer: no invalidates
        do_req(1, 0, 4, 0, 16'h0F0F, "R6");
        do_req(0, 3, 5, 0, 0, "R8");           // shows 9999 was dropped
        for (int b = 0; b < 8; b++) do_req(0, b % 4, b, 0, 16'h3000 + 16'(b), "R2");
        for (int p = 0; p < 4; p++) do_req(0, p, 6, 0, 0, "R2");
        do_req(1, 2, 6, 0, 0, "R4");           // inv p0, p1, p3

        repeat (4) @(negedge clk);
        check(q_msg.size() == 0, "R10", "pending expected messages", q_msg.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule